// File: doc/BRIEF.md
# Platform Interrupt Controller

This block gathers level interrupt requests from a parameterised set of sources and spreads them over a fixed set of processor contexts. Each source carries a programmable priority. Each context holds an enable bitmap with one bit per source, a priority threshold, and a claim/complete register. A source that raises its level line becomes pending. A context sees an interrupt while at least one pending, unclaimed source is enabled for it with a priority above its threshold. Software reads the claim register to take the best such source, services it, and writes the source number back to release it.

All state is reached through a single-cycle 32-bit register port made of request, write flag, byte address and write data. A response strobe and the read data follow one clock later. The port runs a two-state access machine. `ACC_IDLE` moves to `ACC_RESP` when a request arrives. `ACC_RESP` stays there on a back-to-back request and returns to `ACC_IDLE` otherwise. The response strobe is high exactly in `ACC_RESP`. Each context is fixed by a parameter bit as a machine-mode or a supervisor-mode context, and its interrupt appears on the matching one of two output lines.

Register map: source priorities start at 0x0000, one 32-bit word per source. Pending words start at 0x1000. Enable windows start at 0x2000, one every 0x80 bytes per context. Context windows start at 0x4000, one every 0x100 bytes per context.

Top module: `pic_top`

## Requirements
- R1: After reset every pending, claimed, enable, priority and threshold value is zero, `rsp_valid` is low and every interrupt line is low.
- R2: While unclaimed, a source n ≥ 1 whose `irq_src[n]` is high at a clock edge becomes pending, and stays pending after the line drops. It shows as bit n mod 32 of the pending word at 0x1000 + 4·(n/32). Source 0 never becomes pending, and writes to the pending words change nothing.
- R3: A source is a candidate for context c only when it is pending, not claimed, has bit n set in c's enable bitmap, and has a priority strictly above c's threshold.
- R4: The claim result of a context is the candidate with the highest priority. Among equal priorities the lowest source number wins. The result is 0 when there is no candidate.
- R5: A read at context offset 4 (0x4004 + 0x100·c) returns the claim result. When that result is nonzero, the source's pending bit is cleared and its claimed bit is set. A claimed source does not become pending again.
- R6: A write of value v at context offset 4 clears the claimed bit of source v when v is less than the source count. Larger values are ignored.
- R7: A priority write (0x0000 + 4·n) or threshold write (context offset 0) stores the value modulo (PRIO_MAX+1) when PRIO_MAX+1 is a power of two. Otherwise it stores values up to PRIO_MAX and ignores larger ones. Both read back at the same address.
- R8: Enable word w of context c sits at 0x2000 + 0x80·c + 4·w and holds bits for sources 32·w to 32·w+31. Words with w beyond the last bitfield word read as zero and ignore writes. Stored bits above the last source never create a candidate.
- R9: A context's interrupt is high exactly when its claim result is nonzero. It drives `irq_s[c]` when bit c of CTX_MODE is 1 (supervisor) and `irq_m[c]` otherwise. The other line stays low.
- R10: Every request is answered with `rsp_valid` high in the next cycle. `rsp_rdata` then carries the read value, and it is zero for writes and for addresses outside the map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NSRC | Level request per source, sampled synchronously |
| req | input | 1 | Register access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 32 | Read data for the answered request |
| irq_m | output | NCTX | Machine-mode interrupt line per context |
| irq_s | output | NCTX | Supervisor-mode interrupt line per context |

## Verification
The claim arbitration is driven with seeded random mixes of sparse source levels, priority, threshold and enable writes, claim reads and completions with in-range and out-of-range numbers. This shows whether the candidate filter and the winner order agree with an independent model under state that keeps changing. Directed sequences add cases that random traffic seldom reaches. Equal priorities separate the lowest-number tie rule from a last-found rule. A threshold equal to the priority separates strict from inclusive comparison. An out-of-range completion followed by a raised line shows whether the claimed bit survived. A second instance with a non-power-of-two maximum separates the modulo write rule from the reject rule.

// File: rtl/pic_pkg.sv
package pic_pkg;

    // Register access phase of the port
    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

    // Decoded register kind for one request
    typedef enum logic [2:0] {
        RG_NONE  = 3'd0,
        RG_PRIO  = 3'd1,
        RG_PEND  = 3'd2,
        RG_EN    = 3'd3,
        RG_THR   = 3'd4,
        RG_CLAIM = 3'd5
    } reg_kind_e;

endpackage

// File: rtl/pic_prio_filter.sv
module pic_prio_filter #(
    parameter int PRIO_MAX = 7,
    parameter int PW       = 3
) (
    input  logic [31:0]   wval,
    output logic          ok,
    output logic [PW-1:0] val
);
    localparam bit MOD_RULE = (((PRIO_MAX + 1) & PRIO_MAX) == 0);

    // Power-of-two range: keep the low bits. Otherwise: accept only legal values.
    assign ok  = MOD_RULE ? 1'b1 : (wval <= 32'(PRIO_MAX));
    assign val = wval[PW-1:0];
endmodule

// File: rtl/pic_src_bank.sv
module pic_src_bank #(
    parameter int NSRC = 40,
    parameter int PW   = 3,
    parameter int IDW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_lvl,
    input  logic              prio_we,
    input  logic [IDW-1:0]    prio_idx,
    input  logic [PW-1:0]     prio_val,
    input  logic              claim_we,
    input  logic [IDW-1:0]    claim_idx,
    input  logic              done_we,
    input  logic [IDW-1:0]    done_idx,
    output logic [NSRC-1:0]   pend_q,
    output logic [NSRC-1:0]   clmd_q,
    output logic [NSRC*PW-1:0] prio_flat
);
    logic [NSRC-1:0] pend_d;
    logic [NSRC-1:0] clmd_d;
    logic [PW-1:0]   prio_q [NSRC];

    always_comb begin
        pend_d    = pend_q | (irq_lvl & ~clmd_q);
        pend_d[0] = 1'b0;
        clmd_d    = clmd_q;
        if (claim_we) begin
            pend_d[claim_idx] = 1'b0;
            clmd_d[claim_idx] = 1'b1;
        end
        if (done_we) begin
            clmd_d[done_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            clmd_q <= '0;
        end else begin
            pend_q <= pend_d;
            clmd_q <= clmd_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < NSRC; n++) begin
                prio_q[n] <= '0;
            end
        end else if (prio_we) begin
            prio_q[prio_idx] <= prio_val;
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_flat
        assign prio_flat[g*PW +: PW] = prio_q[g];
    end

    AST_PEND_CLAIM_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & clmd_q) == '0); // R5
    AST_SRC0_NEVER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0]); // R2
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done_we |=> !clmd_q[$past(done_idx)]); // R6
endmodule

// File: rtl/pic_ctx_arb.sv
module pic_ctx_arb #(
    parameter int NSRC = 40,
    parameter int PW   = 3,
    parameter int IDW  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    pend,
    input  logic [NSRC-1:0]    clmd,
    input  logic [NSRC-1:0]    en,
    input  logic [NSRC*PW-1:0] prio_flat,
    input  logic [PW-1:0]      thr,
    output logic [IDW-1:0]     win_id,
    output logic               win_hit
);
    logic [PW-1:0] best_p;

    // Linear scan: strict greater-than keeps the lowest number on a tie,
    // and starting from the threshold filters out priorities at or below it.
    always_comb begin
        win_id  = '0;
        win_hit = 1'b0;
        best_p  = thr;
        for (int n = 1; n < NSRC; n++) begin
            if (pend[n] && !clmd[n] && en[n] && (prio_flat[n*PW +: PW] > best_p)) begin
                win_id  = IDW'(n);
                best_p  = prio_flat[n*PW +: PW];
                win_hit = 1'b1;
            end
        end
    end

    AST_WIN_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (prio_flat[win_id*PW +: PW] > thr)); // R3
    AST_WIN_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (pend[win_id] && !clmd[win_id] && en[win_id])); // R3
    AST_NO_WIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> (win_id == '0)); // R4
endmodule

// File: rtl/pic_top.sv
module pic_top #(
    parameter int              NSRC       = 40,
    parameter int              NCTX       = 2,
    parameter int              PRIO_MAX   = 7,
    parameter logic [NCTX-1:0] CTX_MODE   = 2'b10,
    parameter int              AW         = 16,
    parameter int              PRIO_BASE  = 'h0000,
    parameter int              PEND_BASE  = 'h1000,
    parameter int              EN_BASE    = 'h2000,
    parameter int              EN_STRIDE  = 'h80,
    parameter int              CTX_BASE   = 'h4000,
    parameter int              CTX_STRIDE = 'h100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_src,
    input  logic            req,
    input  logic            req_we,
    input  logic [AW-1:0]   req_addr,
    input  logic [31:0]     req_wdata,
    output logic            rsp_valid,
    output logic [31:0]     rsp_rdata,
    output logic [NCTX-1:0] irq_m,
    output logic [NCTX-1:0] irq_s
);
    import pic_pkg::*;

    localparam int NWORDS = (NSRC + 31) / 32;
    localparam int IDW    = $clog2(NSRC);
    localparam int PW     = $clog2(PRIO_MAX + 1);
    localparam int CIW    = (NCTX > 1) ? $clog2(NCTX) : 1;
    localparam int WIW    = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int EN_SH  = $clog2(EN_STRIDE);
    localparam int CTX_SH = $clog2(CTX_STRIDE);
    localparam int EWW    = EN_SH - 2;

    localparam logic [AW-1:0] A_PRIO = AW'(PRIO_BASE);
    localparam logic [AW-1:0] A_PEND = AW'(PEND_BASE);
    localparam logic [AW-1:0] A_EN   = AW'(EN_BASE);
    localparam logic [AW-1:0] A_CTX  = AW'(CTX_BASE);
    localparam logic [AW-1:0] L_PRIO = AW'(NSRC * 4);
    localparam logic [AW-1:0] L_PEND = AW'(NWORDS * 4);
    localparam logic [AW-1:0] L_EN   = AW'(NCTX * EN_STRIDE);
    localparam logic [AW-1:0] L_CTX  = AW'(NCTX * CTX_STRIDE);

    // ---------------- state ----------------
    acc_state_e          acc_q, acc_nx;
    logic [31:0]         rdata_q;
    logic [31:0]         en_q  [NCTX][NWORDS];
    logic [PW-1:0]       thr_q [NCTX];
    logic [NSRC-1:0]     pend_q, clmd_q;
    logic [NSRC*PW-1:0]  prio_flat;
    logic [NCTX*IDW-1:0] win_flat;
    logic [NCTX-1:0]     win_hit;

    // ---------------- decode ----------------
    logic [AW-1:0]     off_p, off_q, off_e, off_c;
    reg_kind_e         rk;
    logic [IDW-1:0]    src_idx;
    logic [WIW-1:0]    q_word;
    logic [CIW-1:0]    e_ctx, c_ctx, r_ctx;
    logic [EWW-1:0]    e_word;
    logic              e_word_ok;
    logic [WIW-1:0]    e_widx;
    logic [CTX_SH-1:0] c_inner;

    assign off_p   = req_addr - A_PRIO;
    assign off_q   = req_addr - A_PEND;
    assign off_e   = req_addr - A_EN;
    assign off_c   = req_addr - A_CTX;
    assign src_idx = IDW'(off_p >> 2);
    assign q_word  = WIW'(off_q >> 2);
    assign e_ctx   = CIW'(off_e >> EN_SH);
    assign e_word  = off_e[EN_SH-1:2];
    assign e_word_ok = (32'(e_word) < NWORDS);
    assign e_widx  = WIW'(e_word);
    assign c_ctx   = CIW'(off_c >> CTX_SH);
    assign c_inner = off_c[CTX_SH-1:0];

    always_comb begin
        rk    = RG_NONE;
        r_ctx = c_ctx;
        if (off_p < L_PRIO) begin
            rk = RG_PRIO;
        end else if (off_q < L_PEND) begin
            rk = RG_PEND;
        end else if (off_e < L_EN) begin
            rk    = RG_EN;
            r_ctx = e_ctx;
        end else if (off_c < L_CTX) begin
            if (c_inner == CTX_SH'(0)) begin
                rk = RG_THR;
            end else if (c_inner == CTX_SH'(4)) begin
                rk = RG_CLAIM;
            end
        end
    end

    // ---------------- write-value filter ----------------
    logic          flt_ok;
    logic [PW-1:0] flt_val;

    pic_prio_filter #(.PRIO_MAX(PRIO_MAX), .PW(PW)) u_filter (
        .wval (req_wdata),
        .ok   (flt_ok),
        .val  (flt_val)
    );

    // ---------------- write and claim strobes ----------------
    logic           wr, rd;
    logic           prio_we, claim_we, done_we;
    logic [IDW-1:0] claim_idx, done_idx;

    assign wr        = req && req_we;
    assign rd        = req && !req_we;
    assign prio_we   = wr && (rk == RG_PRIO) && flt_ok;
    assign claim_idx = win_flat[r_ctx*IDW +: IDW];
    assign claim_we  = rd && (rk == RG_CLAIM) && win_hit[r_ctx];
    assign done_idx  = IDW'(req_wdata);
    assign done_we   = wr && (rk == RG_CLAIM) && (req_wdata < 32'(NSRC));

    pic_src_bank #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lvl   (irq_src),
        .prio_we   (prio_we),
        .prio_idx  (src_idx),
        .prio_val  (flt_val),
        .claim_we  (claim_we),
        .claim_idx (claim_idx),
        .done_we   (done_we),
        .done_idx  (done_idx),
        .pend_q    (pend_q),
        .clmd_q    (clmd_q),
        .prio_flat (prio_flat)
    );

    // ---------------- per-context enable and threshold ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCTX; c++) begin
                thr_q[c] <= '0;
                for (int w = 0; w < NWORDS; w++) begin
                    en_q[c][w] <= '0;
                end
            end
        end else begin
            if (wr && (rk == RG_EN) && e_word_ok) begin
                en_q[e_ctx][e_widx] <= req_wdata;
            end
            if (wr && (rk == RG_THR) && flt_ok) begin
                thr_q[c_ctx] <= flt_val;
            end
        end
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        logic [NSRC-1:0] en_b;

        always_comb begin
            for (int n = 0; n < NSRC; n++) begin
                en_b[n] = en_q[c][n / 32][n % 32];
            end
        end

        pic_ctx_arb #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .pend      (pend_q),
            .clmd      (clmd_q),
            .en        (en_b),
            .prio_flat (prio_flat),
            .thr       (thr_q[c]),
            .win_id    (win_flat[c*IDW +: IDW]),
            .win_hit   (win_hit[c])
        );

        if (CTX_MODE[c]) begin : g_sup
            assign irq_s[c] = win_hit[c];
            assign irq_m[c] = 1'b0;
        end else begin : g_mach
            assign irq_m[c] = win_hit[c];
            assign irq_s[c] = 1'b0;
        end

        AST_THR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            thr_q[c] <= PW'(PRIO_MAX)); // R7
    end

    // ---------------- read mux ----------------
    logic [NWORDS*32-1:0] pend_pad;
    logic [31:0]          rd_next;

    always_comb begin
        pend_pad           = '0;
        pend_pad[NSRC-1:0] = pend_q;
    end

    always_comb begin
        rd_next = '0;
        unique case (rk)
            RG_PRIO:  rd_next = 32'(prio_flat[src_idx*PW +: PW]);
            RG_PEND:  rd_next = pend_pad[q_word*32 +: 32];
            RG_EN:    rd_next = e_word_ok ? en_q[e_ctx][e_widx] : '0;
            RG_THR:   rd_next = 32'(thr_q[c_ctx]);
            RG_CLAIM: rd_next = 32'(claim_idx);
            default:  rd_next = '0;
        endcase
    end

    // ---------------- access state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= ACC_IDLE;
        end else begin
            acc_q <= acc_nx;
        end
    end

    always_comb begin
        unique case (acc_q)
            ACC_IDLE: acc_nx = req ? ACC_RESP : ACC_IDLE;
            ACC_RESP: acc_nx = req ? ACC_RESP : ACC_IDLE;
            default:  acc_nx = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd ? rd_next : '0;
        end
    end

    assign rsp_valid = (acc_q == ACC_RESP);
    assign rsp_rdata = rdata_q;

    AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        claim_we |=> (clmd_q[$past(claim_idx)] && !pend_q[$past(claim_idx)])); // R5
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req)); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (rk == RG_NONE)) |=> (rsp_rdata == '0)); // R10
endmodule

// File: tb/pic_top_bench.sv
`timescale 1ns/1ps
module pic_top_bench;
    localparam int NSRC = 40;
    localparam int NCTX = 2;
    localparam int NW   = 2;
    localparam logic [NCTX-1:0] MODE = 2'b10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_src = '0;
    logic            req = 1'b0, req_we = 1'b0;
    logic [15:0]     req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic            rsp_valid;
    logic [31:0]     rsp_rdata;
    logic [NCTX-1:0] irq_m, irq_s;

    logic            n_req = 1'b0, n_we = 1'b0;
    logic [15:0]     n_addr = '0;
    logic [31:0]     n_wdata = '0;
    logic            n_valid;
    logic [31:0]     n_rdata;
    logic [NCTX-1:0] n_irq_m, n_irq_s;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    pic_top u_pic_top (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_m(irq_m), .irq_s(irq_s)
    );

    pic_top #(.PRIO_MAX(5)) u_pic_top_np (
        .clk(clk), .rst_n(rst_n), .irq_src('0),
        .req(n_req), .req_we(n_we), .req_addr(n_addr), .req_wdata(n_wdata),
        .rsp_valid(n_valid), .rsp_rdata(n_rdata), .irq_m(n_irq_m), .irq_s(n_irq_s)
    );

    // ---------------- reference model ----------------
    bit          m_pend [NSRC];
    bit          m_clm  [NSRC];
    int          m_prio [NSRC];
    bit [31:0]   m_en   [NCTX][NW];
    int          m_thr  [NCTX];

    function automatic void m_clear();
        for (int n = 0; n < NSRC; n++) begin
            m_pend[n] = 0; m_clm[n] = 0; m_prio[n] = 0;
        end
        for (int c = 0; c < NCTX; c++) begin
            m_thr[c] = 0;
            for (int w = 0; w < NW; w++) m_en[c][w] = '0;
        end
    endfunction

    function automatic int m_win(int c);
        int best = 0;
        int bp = m_thr[c];
        for (int n = 1; n < NSRC; n++) begin
            if (m_pend[n] && !m_clm[n] && m_en[c][n/32][n%32] && m_prio[n] > bp) begin
                best = n; bp = m_prio[n];
            end
        end
        return best;
    endfunction

    // kind: 0 none, 1 priority, 2 pending, 3 enable, 4 threshold, 5 claim
    function automatic void dec(logic [15:0] a, output int kind, output int idx, output int c);
        int ai = int'(a);
        kind = 0; idx = 0; c = 0;
        if (ai < NSRC*4) begin
            kind = 1; idx = ai >> 2;
        end else if (ai >= 'h1000 && ai < 'h1000 + NW*4) begin
            kind = 2; idx = (ai - 'h1000) >> 2;
        end else if (ai >= 'h2000 && ai < 'h2000 + NCTX*'h80) begin
            kind = 3; c = (ai - 'h2000) >> 7; idx = ((ai - 'h2000) & 'h7f) >> 2;
        end else if (ai >= 'h4000 && ai < 'h4000 + NCTX*'h100) begin
            c = (ai - 'h4000) >> 8;
            if (((ai - 'h4000) & 'hff) == 0) kind = 4;
            else if (((ai - 'h4000) & 'hff) == 4) kind = 5;
        end
    endfunction

    function automatic logic [31:0] m_read(logic [15:0] a);
        int k, i, c;
        logic [31:0] v = '0;
        dec(a, k, i, c);
        case (k)
            1: v = 32'(m_prio[i]);
            2: for (int b = 0; b < 32; b++) if (i*32 + b < NSRC) v[b] = m_pend[i*32 + b];
            3: v = (i < NW) ? m_en[c][i] : '0;
            4: v = 32'(m_thr[c]);
            5: v = 32'(m_win(c));
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic void m_edge(bit rq, bit we, logic [15:0] a, logic [31:0] d);
        int k, i, c, w;
        bit old_clm [NSRC];
        dec(a, k, i, c);
        w = (rq && !we && k == 5) ? m_win(c) : 0;
        old_clm = m_clm;
        for (int n = 1; n < NSRC; n++) if (irq_src[n] && !old_clm[n]) m_pend[n] = 1;
        if (w != 0) begin m_pend[w] = 0; m_clm[w] = 1; end
        if (rq && we) begin
            case (k)
                1: m_prio[i] = int'(d % 8);
                3: if (i < NW) m_en[c][i] = d;
                4: m_thr[c] = int'(d % 8);
                5: if (d < NSRC) m_clm[d] = 0;
                default: ;
            endcase
        end
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_lines(string tag);
        for (int c = 0; c < NCTX; c++) begin
            bit hit = (m_win(c) != 0);
            check({tag, " R9 machine line"}, 32'(irq_m[c]), 32'(hit && !MODE[c]));
            check({tag, " R9 supervisor line"}, 32'(irq_s[c]), 32'(hit && MODE[c]));
        end
    endtask

    // One request (or idle cycle when rq=0); called and returns at a falling edge.
    task automatic op(string tag, bit rq, bit we, logic [15:0] a, logic [31:0] d,
                      output logic [31:0] got);
        logic [31:0] exp;
        req = rq; req_we = we; req_addr = a; req_wdata = d;
        exp = (rq && !we) ? m_read(a) : '0;
        @(posedge clk);
        m_edge(rq, we, a, d);
        @(negedge clk);
        req = 1'b0; req_we = 1'b0;
        got = rsp_rdata;
        check({tag, " R10 strobe"}, 32'(rsp_valid), 32'(rq));
        if (rq) check({tag, " read data"}, rsp_rdata, exp);
        check_lines(tag);
    endtask

    task automatic wr(string tag, logic [15:0] a, logic [31:0] d);
        logic [31:0] g;
        op(tag, 1'b1, 1'b1, a, d, g);
    endtask

    task automatic rdx(string tag, logic [15:0] a, logic [31:0] exp);
        logic [31:0] g;
        op(tag, 1'b1, 1'b0, a, '0, g);
        check({tag, " directed"}, g, exp);
    endtask

    task automatic idle(int n);
        logic [31:0] g;
        for (int i = 0; i < n; i++) op("idle", 1'b0, 1'b0, '0, '0, g);
    endtask

    task automatic pulse(int s);
        irq_src = '0; irq_src[s] = 1'b1;
        idle(1);
        irq_src = '0;
    endtask

    task automatic do_reset();
        req = 0; req_we = 0; irq_src = '0; n_req = 0; n_we = 0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_clear();
    endtask

    task automatic np_op(bit we, logic [15:0] a, logic [31:0] d, output logic [31:0] got);
        n_req = 1'b1; n_we = we; n_addr = a; n_wdata = d;
        @(posedge clk);
        @(negedge clk);
        n_req = 1'b0; n_we = 1'b0;
        got = n_rdata;
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] g;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1: reset state
        check("R1 strobe", 32'(rsp_valid), 32'd0);
        check("R1 lines", {30'd0, irq_m | irq_s}, 32'd0);
        rdx("R1 pending word", 16'h1000, 32'd0);
        rdx("R1 priority", 16'h0010, 32'd0);
        rdx("R1 threshold", 16'h4100, 32'd0);

        // R2: latching, word placement, source 0, pending writes ignored
        irq_src[0] = 1'b1; irq_src[33] = 1'b1;
        idle(1);
        irq_src = '0;
        idle(1);
        rdx("R2 word1 bit1", 16'h1004, 32'h0000_0002);
        rdx("R2 source0 reserved", 16'h1000, 32'd0);
        wr("R2 pending write", 16'h1000, 32'hFFFF_FFFF);
        rdx("R2 pending write ignored", 16'h1000, 32'd0);

        // R7: modulo rule on the power-of-two instance
        wr("R7 prio", 16'h0008, 32'd13);
        rdx("R7 prio modulo", 16'h0008, 32'd5);
        wr("R7 thr", 16'h4000, 32'd12);
        rdx("R7 thr modulo", 16'h4000, 32'd4);

        // R8: out-of-range enable word, high bits stored
        wr("R8 far word", 16'h200C, 32'hFFFF_FFFF);
        rdx("R8 far word reads zero", 16'h200C, 32'd0);
        wr("R8 upper bits", 16'h2004, 32'hFFFF_FF00);
        rdx("R8 upper bits stored", 16'h2004, 32'hFFFF_FF00);
        check("R8 no phantom candidate", 32'(irq_m[0]), 32'd0);

        // R10: unmapped reads
        rdx("R10 unmapped", 16'h3000, 32'd0);
        rdx("R10 context gap", 16'h4008, 32'd0);

        // R4/R5/R3/R6 directed
        do_reset();
        wr("R4 setup", 16'h000C, 32'd4);
        wr("R4 setup", 16'h0014, 32'd4);
        wr("R4 setup", 16'h0024, 32'd2);
        wr("R4 setup", 16'h2000, 32'h0000_0228);
        irq_src = '0; irq_src[3] = 1; irq_src[5] = 1; irq_src[9] = 1;
        idle(1);
        irq_src = '0;
        check("R9 machine ctx0 raised", 32'(irq_m[0]), 32'd1);
        rdx("R4 tie lowest", 16'h4004, 32'd3);
        rdx("R5 pending cleared", 16'h1000, 32'h0000_0220);
        rdx("R4 next tie", 16'h4004, 32'd5);
        rdx("R4 lower prio", 16'h4004, 32'd9);
        rdx("R4 none", 16'h4004, 32'd0);
        check("R9 machine ctx0 dropped", 32'(irq_m[0]), 32'd0);
        wr("R7 thr", 16'h4000, 32'd2);
        wr("R6 complete 9", 16'h4004, 32'd9);
        pulse(9);
        rdx("R3 equal to threshold", 16'h4004, 32'd0);
        wr("R3 thr lower", 16'h4000, 32'd1);
        rdx("R3 above threshold", 16'h4004, 32'd9);
        wr("R6 out of range", 16'h4004, 32'd40);
        pulse(3);
        rdx("R6 still claimed", 16'h4004, 32'd0);
        rdx("R5 no relatch", 16'h1000, 32'd0);
        wr("R6 complete 3", 16'h4004, 32'd3);
        pulse(3);
        rdx("R6 released", 16'h4004, 32'd3);

        // R9: supervisor context
        do_reset();
        wr("R9 setup", 16'h001C, 32'd3);
        wr("R9 setup", 16'h2080, 32'h0000_0080);
        pulse(7);
        check("R9 supervisor ctx1", 32'(irq_s[1]), 32'd1);
        check("R9 machine ctx1 low", 32'(irq_m[1]), 32'd0);
        check("R9 ctx0 low", 32'(irq_m[0] | irq_s[0]), 32'd0);
        rdx("R9 claim ctx1", 16'h4104, 32'd7);

        // R7: reject rule on the non-power-of-two instance
        np_op(1'b1, 16'h0004, 32'd5, g);
        np_op(1'b0, 16'h0004, 32'd0, g);
        check("R7 reject-rule legal", g, 32'd5);
        np_op(1'b1, 16'h0004, 32'd6, g);
        np_op(1'b0, 16'h0004, 32'd0, g);
        check("R7 reject-rule too large", g, 32'd5);
        np_op(1'b1, 16'h4000, 32'd9, g);
        np_op(1'b0, 16'h4000, 32'd0, g);
        check("R7 reject-rule threshold", g, 32'd0);

        // Random traffic against the model (R2..R10)
        do_reset();
        for (int it = 0; it < 1500; it++) begin
            int sel = $urandom_range(0, 9);
            int c   = $urandom_range(0, NCTX-1);
            irq_src = NSRC'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            case (sel)
                0, 1: wr("R7 rand prio", 16'(4 * $urandom_range(0, NSRC-1)), 32'($urandom_range(0, 15)));
                2:    wr("R8 rand enable", 16'('h2000 + c*'h80 + 4*$urandom_range(0, 3)), $urandom);
                3:    wr("R3 rand thr", 16'('h4000 + c*'h100), 32'($urandom_range(0, 7)));
                4, 5: op("R4 rand claim", 1'b1, 1'b0, 16'('h4004 + c*'h100), '0, g);
                6:    wr("R6 rand complete", 16'('h4004 + c*'h100), 32'($urandom_range(0, 50)));
                7:    op("R2 rand pending", 1'b1, 1'b0, 16'('h1000 + 4*$urandom_range(0, 1)), '0, g);
                8:    op("R10 rand unmapped", 1'b1, 1'b0, 16'('h3000 + 4*$urandom_range(0, 63)), '0, g);
                default: idle(1);
            endcase
        end
        irq_src = '0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule